// File: doc/BRIEF.md
# Bus ownership arbitration controller

This block lets a host controller take and give back the memory bus of an external processor. The host issues one of four commands: reset, request, release or restart. The block then sequences the processor's active-low bus request line, its reset line and the drive enable of the shared address and strobe pins, and it samples the processor's active-low bus acknowledge. The host sees the result as a two-bit ownership state. Bit 1 says whether the processor is running and bit 0 says whether the bus is held.

Every wait for the acknowledge is bounded by a timeout. The timeout counts a slow tick input, so a processor that never answers cannot hang the controller. A wait that times out leaves the bus not held and flags the failure for one cycle. The reset polarity is a static input, so the same block can serve processors whose reset is active high or active low. While a command is in progress the block shows busy and accepts no new command.

Top module: `busown_ctrl`

## Requirements
- R1: After reset the block is in this state: `own_state` = 2'b00, `acquired` = 0, `busreq_n` = 1, `bus_oe` = 0, `busy` = 0, `timeout_err` = 0, and `cpu_rst` asserted at the level `rst_pol` selects.
- R2: Bit 1 of `own_state` means the processor is running and bit 0 means the bus is held (00 reset, 01 reset and held, 10 running, 11 running and held). `acquired` always equals bit 0. Command codes on `cmd_code` are 0 reset, 1 request, 2 release and 3 restart.
- R3: A request in a state that does not hold the bus drives `busreq_n` low, keeps `bus_oe` low and waits. The wait ends at the first clock edge that samples `busack_n` low. At that edge `bus_oe` rises and bit 0 of the state is set. With an acknowledge that follows the request by D cycles, `busy` lasts D+1 cycles.
- R4: If `busack_n` stays high for `TMO_TICKS` ticks during a request wait, `busreq_n` returns high, bit 0 of the state stays clear, and `timeout_err` pulses for exactly one cycle.
- R5: A release in a holding state first lowers `bus_oe`. One cycle later it raises `busreq_n`. It then waits for `busack_n` high or for the timeout, and in both cases it ends with bit 0 clear. On a timeout `timeout_err` pulses for one cycle. `busy` lasts D+2 cycles when the acknowledge follows.
- R6: A reset command from any state floats the bus and asserts `cpu_rst` at once. It raises `busreq_n` one cycle later and ends in state 00 once `busack_n` is high. This takes 2 busy cycles when the acknowledge is already high.
- R7: A restart floats the bus and asserts `cpu_rst` for `RST_CYC` cycles, then releases it and ends with bit 1 set. If the bus was held, `busreq_n` is then pulsed high for `HPULSE_CYC` cycles and re-requested, and the bus is driven again once acknowledged, so the held bit is kept.
- R8: A command that arrives while `busy` is high has no effect. A request while the bus is held, or a release while it is not held, leaves the state unchanged and never raises `busy`.
- R9: `cpu_rst` is high when the internal reset is active if `rst_pol` = 1, and low when it is active if `rst_pol` = 0.
- R10: `bus_oe` is high only while `busreq_n` is low, and it rises only at an edge where `busack_n` was sampled low.
- R11: `busy` is high from the cycle after a command is accepted until the cycle in which the new state appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_code | input | 2 | 0 reset, 1 request, 2 release, 3 restart |
| tmo_tick | input | 1 | Coarse tick that advances acknowledge timeouts |
| rst_pol | input | 1 | 1: processor reset active high; 0: active low |
| busack_n | input | 1 | Processor bus acknowledge, active low |
| busreq_n | output | 1 | Bus request to the processor, active low |
| cpu_rst | output | 1 | Processor reset, polarity set by rst_pol |
| bus_oe | output | 1 | Drive enable for address and strobe pins (strobes held inactive) |
| own_state | output | 2 | Ownership state, encoding per R2 |
| acquired | output | 1 | Bus is held |
| busy | output | 1 | A command sequence is in progress |
| timeout_err | output | 1 | One-cycle pulse when an acknowledge wait timed out |

## Verification
A processor model in the bench answers `busreq_n` on `busack_n` two cycles later, and it can freeze the acknowledge to force timeouts. For each command the driver queues the outcome it expects, together with the length of the busy window: 3 cycles for a request, 4 for a release or for a reset from a holding state, 2 for a reset with the acknowledge already high, and `RST_CYC` for a restart without the bus. The monitor counts busy cycles on falling edges and compares the state, pins and error flag on the first falling edge after busy drops, which is the edge where `timeout_err` is high. Ordering inside a sequence, such as floating before release and the request level while waiting, is sampled on the falling edge right after the accepting clock edge.

// File: rtl/busown_pkg.sv
package busown_pkg;

  typedef enum logic [1:0] {
    OWN_RESET     = 2'b00,
    OWN_RESET_ACQ = 2'b01,
    OWN_RUN       = 2'b10,
    OWN_RUN_ACQ   = 2'b11
  } own_t;

  typedef enum logic [1:0] {
    CMD_RESET   = 2'd0,
    CMD_REQUEST = 2'd1,
    CMD_RELEASE = 2'd2,
    CMD_RESTART = 2'd3
  } cmd_t;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_DROP    = 3'd1,
    PH_WAIT_HI = 3'd2,
    PH_WAIT_LO = 3'd3,
    PH_RST     = 3'd4,
    PH_BRQ     = 3'd5
  } phase_t;

  function automatic own_t with_acq(input own_t s, input logic acq);
    return own_t'({s[1], acq});
  endfunction

  function automatic own_t with_run(input own_t s, input logic run);
    return own_t'({run, s[0]});
  endfunction

endpackage

// File: rtl/busown_rsync.sv
module busown_rsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/busown_tmo.sv
module busown_tmo #(
  parameter int TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic expired
);
  localparam int W = $clog2(TICKS + 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                    cnt_d = W'(TICKS);
    else if (tick && cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R4
  tmo_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !expired);
endmodule

// File: rtl/busown_pcnt.sv
module busown_pcnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = val;
    else if (cnt_q != 0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // R7
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && val != '0) |=> !done);
endmodule

// File: rtl/busown_seq.sv
module busown_seq
  import busown_pkg::*;
#(
  parameter int RST_CYC    = 16,
  parameter int HPULSE_CYC = 2,
  parameter int PW         = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_code,
  input  logic          busack_n,
  input  logic          tmo_exp,
  input  logic          pc_done,
  output logic          tmo_load,
  output logic          pc_load,
  output logic [PW-1:0] pc_val,
  output logic          busreq_n,
  output logic          bus_oe,
  output logic          rst_act,
  output own_t          own_state,
  output logic          busy,
  output logic          timeout_err
);
  phase_t ph_q,  ph_d;
  own_t   st_q,  st_d;
  own_t   tgt_q, tgt_d;
  logic   brq_q, brq_d;
  logic   oe_q,  oe_d;
  logic   ra_q,  ra_d;
  logic   err_q, err_d;
  logic   accept;

  assign accept = (ph_q == PH_IDLE) && cmd_valid;

  always_comb begin
    ph_d     = ph_q;
    st_d     = st_q;
    tgt_d    = tgt_q;
    brq_d    = brq_q;
    oe_d     = oe_q;
    ra_d     = ra_q;
    err_d    = 1'b0;
    tmo_load = 1'b0;
    pc_load  = 1'b0;
    pc_val   = '0;
    unique case (ph_q)
      PH_IDLE: begin
        if (cmd_valid) begin
          unique case (cmd_t'(cmd_code))
            CMD_RESET: begin
              oe_d  = 1'b0;
              ra_d  = 1'b1;
              tgt_d = OWN_RESET;
              ph_d  = PH_DROP;
            end
            CMD_REQUEST: begin
              if (!st_q[0]) begin
                brq_d    = 1'b0;
                tgt_d    = with_acq(st_q, 1'b1);
                tmo_load = 1'b1;
                ph_d     = PH_WAIT_LO;
              end
            end
            CMD_RELEASE: begin
              if (st_q[0]) begin
                oe_d  = 1'b0;
                tgt_d = with_acq(st_q, 1'b0);
                ph_d  = PH_DROP;
              end
            end
            CMD_RESTART: begin
              oe_d    = 1'b0;
              ra_d    = 1'b1;
              tgt_d   = with_run(st_q, 1'b1);
              pc_load = 1'b1;
              pc_val  = PW'(RST_CYC - 1);
              ph_d    = PH_RST;
            end
            default: ;
          endcase
        end
      end
      PH_DROP: begin
        brq_d    = 1'b1;
        tmo_load = 1'b1;
        ph_d     = PH_WAIT_HI;
      end
      PH_WAIT_HI: begin
        if (busack_n) begin
          st_d = tgt_q;
          ph_d = PH_IDLE;
        end else if (tmo_exp) begin
          st_d  = tgt_q;
          err_d = 1'b1;
          ph_d  = PH_IDLE;
        end
      end
      PH_WAIT_LO: begin
        if (!busack_n) begin
          oe_d = 1'b1;
          st_d = tgt_q;
          ph_d = PH_IDLE;
        end else if (tmo_exp) begin
          brq_d = 1'b1;
          st_d  = with_acq(tgt_q, 1'b0);
          err_d = 1'b1;
          ph_d  = PH_IDLE;
        end
      end
      PH_RST: begin
        if (pc_done) begin
          ra_d = 1'b0;
          if (tgt_q[0]) begin
            brq_d   = 1'b1;
            pc_load = 1'b1;
            pc_val  = PW'(HPULSE_CYC - 1);
            ph_d    = PH_BRQ;
          end else begin
            st_d = tgt_q;
            ph_d = PH_IDLE;
          end
        end
      end
      PH_BRQ: begin
        if (pc_done) begin
          brq_d    = 1'b0;
          tmo_load = 1'b1;
          ph_d     = PH_WAIT_LO;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      st_q  <= OWN_RESET;
      tgt_q <= OWN_RESET;
      brq_q <= 1'b1;
      oe_q  <= 1'b0;
      ra_q  <= 1'b1;
      err_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      st_q  <= st_d;
      brq_q <= brq_d;
      oe_q  <= oe_d;
      ra_q  <= ra_d;
      err_q <= err_d;
      if (accept) tgt_q <= tgt_d;
    end
  end

  assign busreq_n    = brq_q;
  assign bus_oe      = oe_q;
  assign rst_act     = ra_q;
  assign own_state   = st_q;
  assign busy        = (ph_q != PH_IDLE);
  assign timeout_err = err_q;

  // R10
  oe_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !$past(busack_n));

  // R5
  float_before_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brq_q) |-> (!oe_q && !$past(oe_q)));

  // R4
  tmo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q);

  // R6
  reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_code == 2'd0) |=> (!oe_q && ra_q && busy));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && ph_q == PH_WAIT_LO && busack_n && !tmo_exp) |=> $stable(st_q));
endmodule

// File: rtl/busown_ctrl.sv
module busown_ctrl
  import busown_pkg::*;
#(
  parameter int TMO_TICKS  = 20,
  parameter int RST_CYC    = 16,
  parameter int HPULSE_CYC = 2,
  parameter int SYNC_STG   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_code,
  input  logic       tmo_tick,
  input  logic       rst_pol,
  input  logic       busack_n,
  output logic       busreq_n,
  output logic       cpu_rst,
  output logic       bus_oe,
  output logic [1:0] own_state,
  output logic       acquired,
  output logic       busy,
  output logic       timeout_err
);
  localparam int MAXP = (RST_CYC > HPULSE_CYC) ? RST_CYC : HPULSE_CYC;
  localparam int PW   = $clog2(MAXP + 1);

  logic          srst_n;
  logic          tmo_load, tmo_exp;
  logic          pc_load, pc_done;
  logic [PW-1:0] pc_val;
  logic          rst_act;
  own_t          st;

  busown_rsync #(.STAGES(SYNC_STG)) u_rsync (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  busown_tmo #(.TICKS(TMO_TICKS)) u_tmo (
    .clk(clk), .rst_n(srst_n), .load(tmo_load), .tick(tmo_tick), .expired(tmo_exp)
  );

  busown_pcnt #(.W(PW)) u_pcnt (
    .clk(clk), .rst_n(srst_n), .load(pc_load), .val(pc_val), .done(pc_done)
  );

  busown_seq #(.RST_CYC(RST_CYC), .HPULSE_CYC(HPULSE_CYC), .PW(PW)) u_seq (
    .clk(clk), .rst_n(srst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .busack_n(busack_n), .tmo_exp(tmo_exp), .pc_done(pc_done),
    .tmo_load(tmo_load), .pc_load(pc_load), .pc_val(pc_val),
    .busreq_n(busreq_n), .bus_oe(bus_oe), .rst_act(rst_act),
    .own_state(st), .busy(busy), .timeout_err(timeout_err)
  );

  assign cpu_rst   = rst_pol ? rst_act : ~rst_act;
  assign own_state = st;
  assign acquired  = st[0];

  // R10
  oe_needs_req_chk: assert property (@(posedge clk) disable iff (!srst_n)
    bus_oe |-> !busreq_n);
endmodule

// File: tb/test_busown_ctrl.sv
module test_busown_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ACK_DLY    = 2;
  localparam int TMO        = 3;
  localparam int RSTC       = 4;
  localparam int HPC        = 2;
  localparam int WD_CYC     = 20000;

  logic clk = 1'b0;
  logic rst_n, cmd_valid, tmo_tick, rst_pol, busack_n, ack_en;
  logic [1:0] cmd_code;
  logic busreq_n, cpu_rst, bus_oe, acquired, busy, timeout_err;
  logic [1:0] own_state;
  logic [ACK_DLY-1:0] ack_sr;
  logic [1:0] tdiv;

  int nchk = 0;
  int nerr = 0;
  int bcnt = 0;
  bit fin  = 0;

  typedef struct {
    logic [1:0] st;
    logic       oe;
    logic       brqn;
    logic       crst;
    logic       err;
    int         lat;
    string      req;
  } exp_t;
  exp_t exq[$];
  exp_t e;

  always #(CLK_PERIOD/2) clk = ~clk;

  busown_ctrl #(.TMO_TICKS(TMO), .RST_CYC(RSTC), .HPULSE_CYC(HPC)) i_busown_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .tmo_tick(tmo_tick), .rst_pol(rst_pol), .busack_n(busack_n),
    .busreq_n(busreq_n), .cpu_rst(cpu_rst), .bus_oe(bus_oe),
    .own_state(own_state), .acquired(acquired), .busy(busy),
    .timeout_err(timeout_err)
  );

  // processor model: acknowledge follows the request ACK_DLY cycles later
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ack_sr <= '1;
    else if (ack_en) ack_sr <= {ack_sr[ACK_DLY-2:0], busreq_n};
  end
  assign busack_n = ack_sr[ACK_DLY-1];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin tdiv <= '0; tmo_tick <= 1'b0; end
    else begin tdiv <= tdiv + 1'b1; tmo_tick <= (tdiv == 2'd3); end
  end

  task automatic chk_eq(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic lvl(input logic active);
    return rst_pol ? active : ~active;
  endfunction

  task automatic push(input logic [1:0] st, input logic oe, input logic brqn,
                      input logic active, input logic err, input int lat, input string req);
    exp_t x;
    x.st = st; x.oe = oe; x.brqn = brqn; x.crst = lvl(active);
    x.err = err; x.lat = lat; x.req = req;
    exq.push_back(x);
  endtask

  task automatic issue(input logic [1:0] c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (exq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic ignored(input logic [1:0] c, input string req);
    logic [1:0] s0;
    s0 = own_state;
    issue(c);
    chk_eq({req, " busy stays low"}, int'(busy), 0);
    repeat (2) @(negedge clk);
    chk_eq({req, " state unchanged"}, int'(own_state), int'(s0));
    chk_eq({req, " still idle"}, int'(busy), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) bcnt = 0;
    else if (busy) bcnt++;
    else if (bcnt != 0) begin
      if (exq.size() == 0) chk_eq("R11 unexpected completion", 1, 0);
      else begin
        e = exq.pop_front();
        chk_eq({e.req, " state"},      int'(own_state),   int'(e.st));
        chk_eq({e.req, " R2 acquired"}, int'(acquired),   int'(e.st[0]));
        chk_eq({e.req, " bus_oe"},     int'(bus_oe),      int'(e.oe));
        chk_eq({e.req, " busreq_n"},   int'(busreq_n),    int'(e.brqn));
        chk_eq({e.req, " cpu_rst"},    int'(cpu_rst),     int'(e.crst));
        chk_eq({e.req, " timeout_err"}, int'(timeout_err), int'(e.err));
        if (e.lat >= 0) chk_eq({e.req, " R11 busy cycles"}, bcnt, e.lat);
      end
      bcnt = 0;
    end
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!fin) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = 2'd0; rst_pol = 1'b1; ack_en = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    chk_eq("R1 state", int'(own_state), 0);
    chk_eq("R1 acquired", int'(acquired), 0);
    chk_eq("R1 busreq_n", int'(busreq_n), 1);
    chk_eq("R1 bus_oe", int'(bus_oe), 0);
    chk_eq("R1 busy", int'(busy), 0);
    chk_eq("R1 timeout_err", int'(timeout_err), 0);
    chk_eq("R1 cpu_rst", int'(cpu_rst), 1);

    // R3 request from reset
    push(2'b01, 1, 0, 1, 0, ACK_DLY + 1, "R3 request");
    issue(2'd1);
    chk_eq("R3 busreq_n low while waiting", int'(busreq_n), 0);
    chk_eq("R3 bus floating while waiting", int'(bus_oe), 0);
    chk_eq("R11 busy after accept", int'(busy), 1);
    wait_done();

    ignored(2'd1, "R8 request when held");

    // R5 release order
    push(2'b00, 0, 1, 1, 0, ACK_DLY + 2, "R5 release");
    issue(2'd2);
    chk_eq("R5 bus floated first", int'(bus_oe), 0);
    chk_eq("R5 request still low", int'(busreq_n), 0);
    @(negedge clk);
    chk_eq("R5 request raised next", int'(busreq_n), 1);
    wait_done();

    ignored(2'd2, "R8 release when free");

    // R7 restart without bus
    push(2'b10, 0, 1, 0, 0, RSTC, "R7 restart");
    issue(2'd3);
    chk_eq("R7 reset asserted", int'(cpu_rst), 1);
    wait_done();

    push(2'b11, 1, 0, 0, 0, ACK_DLY + 1, "R3 request running");
    issue(2'd1);
    wait_done();

    // R7 restart while held
    push(2'b11, 1, 0, 0, 0, -1, "R7 restart held");
    issue(2'd3);
    chk_eq("R7 bus floated during restart", int'(bus_oe), 0);
    chk_eq("R7 reset asserted held", int'(cpu_rst), 1);
    wait_done();

    // R6 reset from running and held
    push(2'b00, 0, 1, 1, 0, ACK_DLY + 2, "R6 reset");
    issue(2'd0);
    chk_eq("R6 reset asserted at once", int'(cpu_rst), 1);
    chk_eq("R6 bus floated at once", int'(bus_oe), 0);
    wait_done();

    // R9 polarity
    rst_pol = 1'b0;
    @(negedge clk);
    chk_eq("R9 active-low reset level", int'(cpu_rst), 0);
    push(2'b10, 0, 1, 0, 0, RSTC, "R9 restart low polarity");
    issue(2'd3);
    wait_done();
    chk_eq("R9 released level low polarity", int'(cpu_rst), 1);
    rst_pol = 1'b1;
    @(negedge clk);
    chk_eq("R9 released level high polarity", int'(cpu_rst), 0);

    // R4 request timeout
    ack_en = 1'b0;
    push(2'b10, 0, 1, 0, 1, -1, "R4 request timeout");
    issue(2'd1);
    chk_eq("R4 request driven", int'(busreq_n), 0);
    wait_done();
    chk_eq("R4 error is one cycle", int'(timeout_err), 0);
    ack_en = 1'b1;
    repeat (4) @(negedge clk);

    // R8 command while busy
    push(2'b11, 1, 0, 0, 0, ACK_DLY + 1, "R8 command while busy");
    issue(2'd1);
    cmd_valid = 1'b1;
    cmd_code  = 2'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();

    // R5 release timeout
    ack_en = 1'b0;
    push(2'b10, 0, 1, 0, 1, -1, "R5 release timeout");
    issue(2'd2);
    wait_done();
    ack_en = 1'b1;
    repeat (4) @(negedge clk);

    // R6 reset with acknowledge already high
    push(2'b00, 0, 1, 1, 0, 2, "R6 reset while free");
    issue(2'd0);
    wait_done();

    fin = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule